// File: doc/BRIEF.md
# Serial Transmit Path with Holding Queue

This block is the transmit side of an asynchronous serial port with a CPU-facing write port. Software writes data bytes to a write-only holding register. The bytes wait in a 16-entry queue when queue mode is on, or in a single slot when it is off. The frame engine takes one byte at a time and sends it on the serial line, least-significant bit first. A start bit leads each frame. An optional parity bit and one or two stop bits follow the data bits. Word length, parity and stop count come from static line-setting inputs. These settings are captured when a byte is loaded, so they stay fixed for that whole frame.

Timing comes from an external enable that pulses at sixteen times the bit rate. Every field of a frame lasts exactly sixteen of these pulses. While data is waiting, frames follow each other with no idle time between them. The block reports two status bits: one says the holding queue is empty, the other says the whole transmitter is empty. It also raises an interrupt request while the queue is empty and the request is enabled. This request appears as soon as reset ends. Software clears it by writing a byte.

Top module: `sertx_top`

## Requirements
- R1: During reset and directly after it, `txd` is 1, `line_status` reads 8'h60 (bit 5 = holding empty = 1, bit 6 = transmitter empty = 1, all other bits 0).
- R2: `irq` is 1 exactly when `irq_en` is 1 and status bit 5 (holding empty) is 1; with `irq_en` = 0, `irq` stays 0.
- R3: In the cycle after a write (`wr_en` = 1 at a clock edge), status bit 5 and `irq` read 0.
- R4: Data bits go out least-significant bit first; `word_len` selects 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits, and higher bits of the written byte are not sent.
- R5: A frame starts with a 0 start bit. Every field lasts exactly 16 `baud_tick` pulses. `txd` never changes during a frame in a cycle without a `baud_tick`.
- R6: With `par_en` = 1, a parity bit follows the data bits. With `par_even` = 1, the data bits plus the parity bit hold an even number of ones. With `par_even` = 0, they hold an odd number.
- R7: After the data and any parity bit, the frame sends one stop bit of 1. With `two_stop` = 1 it sends two.
- R8: With `fifo_mode` = 1, up to 16 bytes wait in the queue in addition to the byte being sent. Writes while the queue is full are dropped. Bytes leave in write order.
- R9: With `fifo_mode` = 0, only one byte waits besides the byte being sent, and further writes are dropped.
- R10: A queued byte starts its start bit right when the previous last stop bit ends, with no idle gap, so start-to-start spacing equals the frame length.
- R11: Status bit 6 is 1 only when the queue is empty and no frame is in progress. Status bit 5 is 1 whenever the queue is empty, even while a frame is being sent.
- R12: While the transmitter is empty, `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte written to the holding register |
| fifo_mode | input | 1 | 1 = 16-entry queue, 0 = single holding slot |
| word_len | input | 2 | Data bits per frame: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| irq_en | input | 1 | Enables the holding-empty interrupt request |
| txd | output | 1 | Serial output line |
| line_status | output | 8 | Bit 5 holding empty, bit 6 transmitter empty, others 0 |
| irq | output | 1 | Holding-empty interrupt request |

## Verification
The hardest case to reach is a queue that is exactly full while a frame is still in progress. In that state, one more write must be dropped, and every accepted byte must still leave without an idle gap. The bench sets the bit-rate enable to fire every cycle and writes eighteen bytes on consecutive cycles. The first byte moves into the frame engine at once, sixteen more fill the queue, and the last byte is dropped. The bench then measures start-to-start spacing in enable pulses for all seventeen frames. It also checks that the holding-empty status rises while the final frame is still being sent.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int OVS     = 16;
  localparam int OVS_W   = $clog2(OVS);
  localparam int LS_W    = 8;
  localparam int LS_HOLD = 5;
  localparam int LS_TEMT = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } frame_st_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       pen;
    logic       peven;
    logic       stop2;
  } frame_cfg_t;

  // index of the final data bit for a word-length code (00 -> 5 bits)
  function automatic logic [IDX_W-1:0] final_idx(input logic [1:0] wlen);
    return IDX_W'(4) + IDX_W'(wlen);
  endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_slot,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          full, accept, take;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (fill_q == '0);
  assign full   = single_slot ? (fill_q != '0) : (fill_q == CW'(DEPTH));
  assign take   = pop && !empty;
  assign accept = push && (!full || take);
  assign head   = mem[rd_q];
  assign fill   = fill_q;

  always_comb begin
    wr_d   = accept ? bump(wr_q) : wr_q;
    rd_d   = take ? bump(rd_q) : rd_q;
    fill_d = fill_q + CW'(accept) - CW'(take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              avail,
  input  logic [DATA_W-1:0] data_in,
  input  frame_cfg_t        cfg_in,
  output logic              pop,
  output logic              txd,
  output logic              busy
);
  frame_st_e         st_q, st_d;
  logic [OVS_W-1:0]  sub_q, sub_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              stp_q, stp_d;
  frame_cfg_t        cfg_q, cfg_d;
  logic              field_end, do_load;

  assign field_end = tick && (sub_q == OVS_W'(OVS - 1));

  always_comb begin
    st_d    = st_q;
    sub_d   = sub_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    par_d   = par_q;
    stp_d   = stp_q;
    cfg_d   = cfg_q;
    do_load = 1'b0;
    if (st_q != S_IDLE && tick) sub_d = sub_q + 1'b1;
    unique case (st_q)
      S_IDLE:  if (avail) do_load = 1'b1;
      S_START: if (field_end) begin
        st_d  = S_DATA;
        idx_d = '0;
      end
      S_DATA: if (field_end) begin
        par_d = par_q ^ sh_q[0];
        sh_d  = sh_q >> 1;
        if (idx_q == final_idx(cfg_q.wlen)) begin
          st_d  = cfg_q.pen ? S_PAR : S_STOP;
          stp_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_PAR: if (field_end) begin
        st_d  = S_STOP;
        stp_d = 1'b0;
      end
      S_STOP: if (field_end) begin
        if (cfg_q.stop2 && !stp_q) stp_d = 1'b1;
        else if (avail)            do_load = 1'b1;
        else                       st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    if (do_load) begin
      st_d  = S_START;
      sub_d = '0;
      sh_d  = data_in;
      par_d = 1'b0;
      cfg_d = cfg_in;
    end
  end

  assign pop  = do_load;
  assign busy = (st_q != S_IDLE);

  always_comb begin
    unique case (st_q)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh_q[0];
      S_PAR:   txd = cfg_q.peven ? par_q : ~par_q;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sub_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      stp_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      par_q <= par_d;
      stp_q <= stp_d;
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int FILL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fifo_mode,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              two_stop,
  input  logic              irq_en,
  output logic              txd,
  output logic [LS_W-1:0]   line_status,
  output logic              irq
);
  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic              fifo_empty, tx_pop, tx_busy;
  logic [DATA_W-1:0] fifo_head;
  logic [FILL_W-1:0] fifo_fill;
  frame_cfg_t        cfg_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign cfg_w = '{wlen: word_len, pen: par_en, peven: par_even, stop2: two_stop};

  sertx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .single_slot(!fifo_mode),
    .push       (wr_en),
    .push_data  (wr_data),
    .pop        (tx_pop),
    .head       (fifo_head),
    .empty      (fifo_empty),
    .fill       (fifo_fill)
  );

  sertx_shifter u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (baud_tick),
    .avail  (!fifo_empty),
    .data_in(fifo_head),
    .cfg_in (cfg_w),
    .pop    (tx_pop),
    .txd    (txd),
    .busy   (tx_busy)
  );

  always_comb begin
    line_status          = '0;
    line_status[LS_HOLD] = fifo_empty;
    line_status[LS_TEMT] = fifo_empty && !tx_busy;
  end

  assign irq = irq_en && fifo_empty;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          baud_tick,
  input logic          wr_en,
  input logic          txd,
  input logic [7:0]    line_status,
  input logic          irq,
  input logic          busy,
  input logic [CW-1:0] fill
);
  // R3: a write leaves the holding queue non-empty and the request low
  p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!line_status[5] && !irq));

  // R5: no tick, no movement on the line within a frame
  p_hold_without_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(txd));

  // R8: queue occupancy never exceeds its depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R11: transmitter empty implies holding empty
  p_temt_needs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[6] |-> line_status[5]);

  // R12: an empty transmitter keeps the line high
  p_idle_line_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[6] |-> txd);
endmodule

bind sertx_top sertx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .baud_tick  (baud_tick),
  .wr_en      (wr_en),
  .txd        (txd),
  .line_status(line_status),
  .irq        (irq),
  .busy       (tx_busy),
  .fill       (fifo_fill)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       fifo_mode;
  logic [1:0] word_len;
  logic       par_en, par_even, two_stop, irq_en;
  logic       txd;
  logic [7:0] line_status;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_period = 4;
  bit tick_on = 1'b1;
  int div = 0;
  int tick_total = 0;
  bit mon_on = 1'b0;
  int cfg_bits = 8;
  bit cfg_pen = 1'b0, cfg_even = 1'b0, cfg_stop2 = 1'b0;
  logic [7:0] rxq [$];
  int         rxt [$];

  sertx_top dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .two_stop(two_stop), .irq_en(irq_en), .txd(txd), .line_status(line_status), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!tick_on) begin
      baud_tick <= 1'b0;
    end else if (div >= tick_period - 1) begin
      baud_tick <= 1'b1;
      div = 0;
    end else begin
      baud_tick <= 1'b0;
      div = div + 1;
    end
  end

  always @(posedge clk) if (baud_tick) tick_total <= tick_total + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (baud_tick) c++;
    end
    @(negedge clk);
  endtask

  // serial line monitor: decodes frames with the current bench settings
  initial begin : mon
    logic [7:0] d;
    logic       pbit;
    forever begin
      if (mon_on && txd === 1'b0) begin
        rxt.push_back(tick_total);
        d = '0;
        wait_ticks(OVS/2);
        chk("R5", "start bit level", 32'(txd), 32'd0);
        for (int i = 0; i < cfg_bits; i++) begin
          wait_ticks(OVS);
          d[i] = txd;
        end
        if (cfg_pen) begin
          wait_ticks(OVS);
          pbit = cfg_even ? ^d : ~^d;
          chk("R6", "parity bit", 32'(txd), 32'(pbit));
        end
        for (int s = 0; s < (cfg_stop2 ? 2 : 1); s++) begin
          wait_ticks(OVS);
          chk("R7", "stop bit level", 32'(txd), 32'd1);
        end
        rxq.push_back(d);
      end else begin
        @(negedge clk);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    summary();
    $finish;
  end

  task automatic set_cfg(input int bits, input bit pen, input bit even, input bit stop2);
    cfg_bits = bits; cfg_pen = pen; cfg_even = even; cfg_stop2 = stop2;
    word_len = 2'(bits - 5); par_en = pen; par_even = even; two_stop = stop2;
  endtask

  task automatic wr_burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = base + 8'(i);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (!line_status[6]) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "txd in reset", 32'(txd), 32'd1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "txd after reset", 32'(txd), 32'd1);
    chk("R1", "status after reset", 32'(line_status), 32'h60);
    chk("R2", "irq enabled and holding empty", 32'(irq), 32'd1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R2", "irq with enable off", 32'(irq), 32'd0);
    irq_en = 1'b1;
  endtask

  task automatic t_irq_clear();
    fifo_mode = 1'b0;
    set_cfg(8, 1'b0, 1'b0, 1'b0);
    rxq.delete(); rxt.delete();
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hB4;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3", "holding empty after write", 32'(line_status[5]), 32'd0);
    chk("R3", "irq after write", 32'(irq), 32'd0);
    @(negedge clk);
    chk("R11", "holding empty once byte loaded", 32'(line_status[5]), 32'd1);
    chk("R11", "transmitter empty while sending", 32'(line_status[6]), 32'd0);
    chk("R2", "irq back with holding empty", 32'(irq), 32'd1);
    drain();
    chk("R4", "8-bit frame count", 32'(rxq.size()), 32'd1);
    if (rxq.size() > 0) chk("R4", "8-bit data lsb first", 32'(rxq[0]), 32'hB4);
  endtask

  task automatic t_frame(input int bits, input bit pen, input bit even, input bit stop2, input logic [7:0] b);
    logic [7:0] mask;
    mask = 8'((1 << bits) - 1);
    set_cfg(bits, pen, even, stop2);
    rxq.delete(); rxt.delete();
    wr_burst(1, b);
    drain();
    chk("R4", "frame count", 32'(rxq.size()), 32'd1);
    if (rxq.size() > 0) chk("R4", "data by word length", 32'(rxq[0]), 32'(b & mask));
  endtask

  task automatic t_tick_pause();
    logic v;
    int changes = 0;
    set_cfg(8, 1'b0, 1'b0, 1'b0);
    rxq.delete(); rxt.delete();
    wr_burst(1, 8'h3C);
    repeat (30) @(negedge clk);
    tick_on = 1'b0;
    repeat (2) @(negedge clk);
    v = txd;
    repeat (40) begin
      @(negedge clk);
      if (txd !== v) changes++;
    end
    chk("R5", "line changes without ticks", 32'(changes), 32'd0);
    tick_on = 1'b1;
    drain();
    if (rxq.size() > 0) chk("R5", "data after pause", 32'(rxq[0]), 32'h3C);
    else chk("R5", "frame after pause", 32'd0, 32'd1);
  endtask

  task automatic t_fifo_burst();
    int flen;
    fifo_mode = 1'b1;
    tick_period = 1;
    set_cfg(8, 1'b0, 1'b0, 1'b0);
    flen = OVS * 10;
    rxq.delete(); rxt.delete();
    wr_burst(18, 8'h40);
    while (rxt.size() < 17) @(negedge clk);
    chk("R11", "holding empty during last frame", 32'(line_status[5]), 32'd1);
    chk("R11", "transmitter busy during last frame", 32'(line_status[6]), 32'd0);
    drain();
    chk("R8", "frames delivered from full queue", 32'(rxq.size()), 32'd17);
    for (int i = 0; i < rxq.size(); i++)
      chk("R8", "queued data in order", 32'(rxq[i]), 32'(8'h40 + 8'(i)));
    for (int i = 1; i < rxt.size(); i++)
      chk("R10", "start-to-start spacing", 32'(rxt[i] - rxt[i-1]), 32'(flen));
    tick_period = 4;
  endtask

  task automatic t_single_slot();
    fifo_mode = 1'b0;
    set_cfg(7, 1'b1, 1'b1, 1'b0);
    rxq.delete(); rxt.delete();
    wr_burst(3, 8'h21);
    drain();
    chk("R9", "frames in single-slot mode", 32'(rxq.size()), 32'd2);
    if (rxq.size() == 2) begin
      chk("R9", "first byte", 32'(rxq[0]), 32'h21);
      chk("R9", "second byte", 32'(rxq[1]), 32'h22);
      chk("R10", "single-slot spacing", 32'(rxt[1] - rxt[0]), 32'(OVS * 10));
    end
  endtask

  task automatic t_idle();
    int lows = 0;
    repeat (100) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R12", "idle line low cycles", 32'(lows), 32'd0);
    chk("R12", "transmitter empty when idle", 32'(line_status[6]), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; fifo_mode = 1'b1; irq_en = 1'b1;
    word_len = 2'b11; par_en = 1'b0; par_even = 1'b0; two_stop = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    mon_on = 1'b1;
    t_irq_clear();
    t_frame(5, 1'b0, 1'b0, 1'b0, 8'hD5);
    t_frame(6, 1'b1, 1'b1, 1'b0, 8'h2B);
    t_frame(7, 1'b1, 1'b0, 1'b1, 8'h5A);
    t_frame(8, 1'b1, 1'b1, 1'b1, 8'hC3);
    t_frame(8, 1'b1, 1'b0, 1'b0, 8'h81);
    t_tick_pause();
    t_fifo_burst();
    t_single_slot();
    t_idle();
    summary();
    $finish;
  end
endmodule